// File: doc/BRIEF.md
# Masked Vector Element Slide Unit

This block moves the elements of a small vector register array by a set distance. It handles four kinds of move. Slide-up shifts elements to higher indices by an offset. Slide-down shifts them to lower indices by an offset. The two slide-by-one variants shift by exactly one position and put a scalar into the element that the move leaves empty. The unit works through one destination element per clock. It starts at the first index the operation permits and stops at the active vector length.

Each operation is configured by four settings:
- an element width of 8, 16, 32 or 64 bits;
- a register-group size of 1, 2 or 4 registers;
- an optional mask, held in register 0;
- a programmable starting element.

The unit captures the mask at launch. A masked-off element keeps its old value.

Before an upward move starts, the unit checks whether the destination and source groups overlap. An overlapping upward request is rejected: the unit writes nothing and gives a one-cycle illegal pulse. When an operation finishes, the unit pulses done, sets a sticky dirty flag and clears the starting element back to zero.

The array is stored inside the block. A byte-wide load port fills it and a byte-wide read port returns its contents, so a caller can prepare operands and inspect results.

Top module: `slide_unit`

## Requirements
- R1: After synchronous reset, busy, done, illegal and dirty are 0, vstart_q is 0 and every storage byte reads 0.
- R2: Slide-up (op 0) starts at the larger of vstart_q and offset, writes destination element i with source element i−offset, and leaves every destination element below the start index unchanged, including the case where the offset is at or beyond vl.
- R3: Slide-down (op 1) writes destination element i with source element i+offset when that sum is below VLMAX and with zero otherwise; the sum is formed without wrap, so a very large offset yields zeros.
- R4: Slide-up-by-one (op 2) writes the low element-width bits of the scalar into element 0 and source element i−1 into element i > 0.
- R5: Slide-down-by-one (op 3) writes source element i+1 when i+1 < vl, and writes the low element-width bits of the scalar into element vl−1.
- R6: With mask_en = 1, element i is written only when bit i of register 0 is 1; bit i is bit (i mod 8) of byte i/8 of register 0. The mask is captured at launch, so writes to register 0 during the run do not change which elements are written.
- R7: ew_sel 0/1/2/3 selects 1/2/4/8-byte elements. Element i of the group based at register r occupies the bytes from r·VLENB + i·bytes upward, least significant byte first. Bytes outside the processed active elements are not changed.
- R8: Processing begins no lower than vstart_q, which vstart_set loads while idle. Elements below vstart_q are unchanged, and vstart_q reads 0 when done is pulsed.
- R9: On completion, done is high for exactly one cycle, busy falls in the same cycle, and dirty becomes 1 and stays 1 until reset.
- R10: An upward request (op 0 or 2) whose register ranges [vd, vd+n) and [vs, vs+n) intersect pulses illegal for one cycle. It writes nothing, raises no done and leaves vstart_q unchanged. Downward requests may overlap and behave as an in-place ascending copy.
- R11: While busy, start, vstart_set and ld_en are ignored, and the running operation's parameters do not change.
- R12: grp_sel 0/1/2 gives groups of 1/2/4 registers with VLMAX = group bytes / element bytes; grp_sel 3 is rejected with an illegal pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, sampled while idle |
| op_in | input | 2 | 0 slide-up, 1 slide-down, 2 up-by-one, 3 down-by-one |
| mask_en | input | 1 | 1 = element writes gated by register 0 |
| ew_sel | input | 2 | Element width: 8/16/32/64 bits |
| grp_sel | input | 2 | Group size: 1/2/4 registers, 3 reserved |
| vd_sel | input | 3 | Destination group base register |
| vs_sel | input | 3 | Source group base register |
| offset | input | 16 | Slide distance for ops 0 and 1 |
| scalar | input | 64 | Fill value for ops 2 and 3 |
| vl_in | input | 6 | Active vector length |
| vstart_set | input | 1 | Load vstart_q from vstart_din while idle |
| vstart_din | input | 6 | New starting element |
| ld_en | input | 1 | Byte write into storage while idle |
| ld_addr | input | 6 | Byte address for loads |
| ld_data | input | 8 | Byte to load |
| rd_addr | input | 6 | Byte address for reads |
| rd_data | output | 8 | Storage byte at rd_addr |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle rejection pulse |
| dirty | output | 1 | Sticky: some operation completed |
| vstart_q | output | 6 | Current starting element |

## Verification
The main function is exercised with a table of launches that covers all four moves at every element width and group size. The entries differ in offset (zero, short, past vl, and a maximal offset), in starting element and in mask on or off. A full-storage comparison after each run separates source-index errors, missing zero fill, wrong scalar truncation and writes that stray outside the active range. Directed cases then drive an overlapping upward request, the same overlap on an in-place downward move, and the reserved group size. They also issue a launch whose destination overwrites the mask register, and requests arriving while the unit is busy. Each of these separates capture-at-launch or ignore-while-busy behaviour from a design that reacts live.

// File: rtl/slide_pkg.sv
package slide_pkg;

    localparam int ELEM_W   = 64;
    localparam int ELEM_BYT = ELEM_W / 8;

    typedef enum logic [1:0] {
        OP_UP    = 2'd0,
        OP_DOWN  = 2'd1,
        OP_UP1   = 2'd2,
        OP_DOWN1 = 2'd3
    } slide_op_e;

    typedef enum logic [1:0] {
        PICK_ELEM   = 2'd0,
        PICK_SCALAR = 2'd1,
        PICK_ZERO   = 2'd2
    } pick_e;

    function automatic logic [3:0] ew_bytes(input logic [1:0] ew);
        return 4'd1 << ew;
    endfunction

    function automatic logic goes_up(input slide_op_e op);
        return (op == OP_UP) || (op == OP_UP1);
    endfunction

endpackage

// File: rtl/slide_overlap.sv
module slide_overlap #(
    parameter int REG_W = 3
) (
    input  logic [REG_W-1:0] reg_a,
    input  logic [REG_W-1:0] reg_b,
    input  logic [2:0]       span,
    output logic             hit
);
    localparam int W = REG_W + 3;

    logic [W-1:0] a_lo, b_lo, n;

    assign a_lo = W'(reg_a);
    assign b_lo = W'(reg_b);
    assign n    = W'(span);
    assign hit  = (a_lo < b_lo + n) && (b_lo < a_lo + n);
endmodule

// File: rtl/slide_pick.sv
module slide_pick
    import slide_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int OFF_W = 16
) (
    input  slide_op_e        op,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] vl,
    input  logic [IDX_W-1:0] vlmax,
    input  logic [OFF_W-1:0] offset,
    output pick_e            pick,
    output logic [IDX_W-1:0] src_idx
);
    localparam int SUM_W = ((OFF_W > IDX_W) ? OFF_W : IDX_W) + 1;

    logic [SUM_W-1:0] fwd;
    logic [SUM_W-1:0] nxt;

    assign fwd = SUM_W'(idx) + SUM_W'(offset);
    assign nxt = SUM_W'(idx) + SUM_W'(1);

    always_comb begin
        pick    = PICK_ELEM;
        src_idx = '0;
        unique case (op)
            OP_UP:   src_idx = idx - IDX_W'(offset);
            OP_DOWN: begin
                if (fwd < SUM_W'(vlmax)) src_idx = fwd[IDX_W-1:0];
                else                     pick    = PICK_ZERO;
            end
            OP_UP1: begin
                if (idx == '0) pick    = PICK_SCALAR;
                else           src_idx = idx - IDX_W'(1);
            end
            OP_DOWN1: begin
                if (nxt < SUM_W'(vl)) src_idx = nxt[IDX_W-1:0];
                else                  pick    = PICK_SCALAR;
            end
        endcase
    end
endmodule

// File: rtl/slide_unit.sv
module slide_unit
    import slide_pkg::*;
#(
    parameter  int NREG   = 8,
    parameter  int VLENB  = 8,
    parameter  int OFF_W  = 16,
    localparam int REG_W  = $clog2(NREG),
    localparam int BYTES  = NREG * VLENB,
    localparam int BA_W   = $clog2(BYTES),
    localparam int MAXVL  = 4 * VLENB,
    localparam int IDX_W  = $clog2(MAXVL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op_in,
    input  logic              mask_en,
    input  logic [1:0]        ew_sel,
    input  logic [1:0]        grp_sel,
    input  logic [REG_W-1:0]  vd_sel,
    input  logic [REG_W-1:0]  vs_sel,
    input  logic [OFF_W-1:0]  offset,
    input  logic [ELEM_W-1:0] scalar,
    input  logic [IDX_W-1:0]  vl_in,
    input  logic              vstart_set,
    input  logic [IDX_W-1:0]  vstart_din,
    input  logic              ld_en,
    input  logic [BA_W-1:0]   ld_addr,
    input  logic [7:0]        ld_data,
    input  logic [BA_W-1:0]   rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              dirty,
    output logic [IDX_W-1:0]  vstart_q
);
    localparam int VB_LG  = $clog2(VLENB);
    localparam int MB_W   = $clog2(MAXVL);
    localparam int EOFF_W = IDX_W + 3;
    localparam int SUM_W  = ((OFF_W > IDX_W) ? OFF_W : IDX_W) + 1;

    typedef struct packed {
        slide_op_e         op;
        logic              masked;
        logic [1:0]        ew;
        logic [REG_W-1:0]  vd;
        logic [REG_W-1:0]  vs;
        logic [OFF_W-1:0]  off;
        logic [ELEM_W-1:0] sc;
        logic [IDX_W-1:0]  vl;
        logic [IDX_W-1:0]  vlmax;
    } cfg_t;

    logic [7:0]       mem [BYTES];
    cfg_t             cfg_q, cfg_d;
    logic [MAXVL-1:0] mask_q, v0_bits;
    logic [IDX_W-1:0] idx_q;

    // launch-side decode
    slide_op_e        op_l;
    logic [2:0]       span;
    logic             ovl_hit, bad_start;
    logic [SUM_W-1:0] first_w;
    logic [IDX_W-1:0] first_idx;

    assign op_l = slide_op_e'(op_in);
    assign span = 3'd1 << grp_sel;

    slide_overlap #(.REG_W(REG_W)) u_ovl (
        .reg_a(vd_sel), .reg_b(vs_sel), .span(span), .hit(ovl_hit)
    );

    assign bad_start = (grp_sel == 2'd3) || (goes_up(op_l) && ovl_hit);

    always_comb begin
        cfg_d.op     = op_l;
        cfg_d.masked = mask_en;
        cfg_d.ew     = ew_sel;
        cfg_d.vd     = vd_sel;
        cfg_d.vs     = vs_sel;
        cfg_d.off    = offset;
        cfg_d.sc     = scalar;
        cfg_d.vl     = vl_in;
        cfg_d.vlmax  = IDX_W'((32'(VLENB) << grp_sel) >> ew_sel);
        first_w      = SUM_W'(vstart_q);
        if (op_l == OP_UP && SUM_W'(offset) > first_w) first_w = SUM_W'(offset);
        first_idx = (first_w >= SUM_W'(vl_in)) ? vl_in : first_w[IDX_W-1:0];
    end

    for (genvar j = 0; j < MAXVL; j++) begin : g_mask
        assign v0_bits[j] = mem[j / 8][j % 8];
    end

    // element path
    pick_e             pick;
    logic [IDX_W-1:0]  src_idx;
    logic [BA_W-1:0]   src_addr, dst_addr;
    logic [ELEM_W-1:0] src_elem, wval;
    logic              in_range, wr_en;

    slide_pick #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_pick (
        .op(cfg_q.op), .idx(idx_q), .vl(cfg_q.vl), .vlmax(cfg_q.vlmax),
        .offset(cfg_q.off), .pick(pick), .src_idx(src_idx)
    );

    assign src_addr = {cfg_q.vs, VB_LG'(0)} + BA_W'(EOFF_W'(src_idx) << cfg_q.ew);
    assign dst_addr = {cfg_q.vd, VB_LG'(0)} + BA_W'(EOFF_W'(idx_q) << cfg_q.ew);
    assign in_range = idx_q < cfg_q.vl;
    assign wr_en    = busy && in_range && (!cfg_q.masked || mask_q[idx_q[MB_W-1:0]]);

    always_comb begin
        src_elem = '0;
        for (int k = 0; k < ELEM_BYT; k++) begin
            if (k < int'(ew_bytes(cfg_q.ew)))
                src_elem[8*k +: 8] = mem[src_addr + BA_W'(k)];
        end
        unique case (pick)
            PICK_ELEM:   wval = src_elem;
            PICK_SCALAR: wval = cfg_q.sc;
            default:     wval = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < BYTES; a++) mem[a] <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < ELEM_BYT; k++) begin
                if (k < int'(ew_bytes(cfg_q.ew)))
                    mem[dst_addr + BA_W'(k)] <= wval[8*k +: 8];
            end
        end else if (ld_en && !busy) begin
            mem[ld_addr] <= ld_data;
        end
    end

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            illegal  <= 1'b0;
            dirty    <= 1'b0;
            vstart_q <= '0;
            idx_q    <= '0;
            cfg_q    <= '0;
            mask_q   <= '0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            if (!busy) begin
                if (start) begin
                    if (bad_start) begin
                        illegal <= 1'b1;
                    end else begin
                        busy   <= 1'b1;
                        cfg_q  <= cfg_d;
                        mask_q <= v0_bits;
                        idx_q  <= first_idx;
                    end
                end else if (vstart_set) begin
                    vstart_q <= vstart_din;
                end
            end else if (in_range) begin
                idx_q <= idx_q + IDX_W'(1);
            end else begin
                busy     <= 1'b0;
                done     <= 1'b1;
                dirty    <= 1'b1;
                vstart_q <= '0;
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    // R9
    dirty_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(dirty) |-> dirty);
    // R8
    vstart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (vstart_q == '0));
    // R10
    illegal_no_run_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!busy && !done));
    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));
    // R2
    up_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cfg_q.op == OP_UP) |-> (SUM_W'(idx_q) >= SUM_W'(cfg_q.off)));
endmodule

// File: tb/slide_unit_bench.sv
module slide_unit_bench;
    localparam int VLENB = 8;
    localparam int BYTES = 64;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  sew;
        logic [1:0]  lmul;
        logic [2:0]  vd;
        logic [2:0]  vs;
        logic [15:0] off;
        logic [5:0]  vl;
        logic [5:0]  vst;
        logic        msk;
        logic [63:0] sc;
    } vec_t;

    // op, sew, lmul, vd, vs, off, vl, vstart, mask, scalar
    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 2'd0, 2'd0, 3'd1, 3'd2, 16'd3,      6'd8,  6'd0, 1'b0, 64'h0},                 // R2
        '{2'd0, 2'd1, 2'd1, 3'd4, 3'd2, 16'd2,      6'd7,  6'd5, 1'b1, 64'h0},                 // R2 R6 R8
        '{2'd1, 2'd0, 2'd1, 3'd2, 3'd4, 16'd5,      6'd16, 6'd0, 1'b0, 64'h0},                 // R3 R12
        '{2'd1, 2'd2, 2'd0, 3'd3, 3'd5, 16'd1,      6'd2,  6'd0, 1'b1, 64'h0},                 // R3 R6 R7
        '{2'd2, 2'd3, 2'd2, 3'd4, 3'd0, 16'd0,      6'd4,  6'd0, 1'b0, 64'h1122334455667788}, // R4 R7
        '{2'd2, 2'd0, 2'd0, 3'd1, 3'd2, 16'd0,      6'd6,  6'd2, 1'b1, 64'hAB},               // R4 R8
        '{2'd3, 2'd1, 2'd0, 3'd6, 3'd7, 16'd0,      6'd3,  6'd0, 1'b0, 64'hFFFFFFFFFFFFBEEF}, // R5 R7
        '{2'd3, 2'd0, 2'd2, 3'd4, 3'd0, 16'd0,      6'd32, 6'd0, 1'b1, 64'h5A},               // R5 R6
        '{2'd0, 2'd0, 2'd0, 3'd1, 3'd3, 16'd9,      6'd8,  6'd0, 1'b0, 64'h0},                 // R2 offset past vl
        '{2'd1, 2'd0, 2'd0, 3'd1, 3'd3, 16'hFFFF,   6'd8,  6'd0, 1'b0, 64'h0},                 // R3 huge offset
        '{2'd0, 2'd3, 2'd1, 3'd6, 3'd4, 16'd1,      6'd2,  6'd0, 1'b1, 64'h0}                  // R2 R7 64-bit
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op_in = '0;
    logic        mask_en = 1'b0;
    logic [1:0]  ew_sel = '0;
    logic [1:0]  grp_sel = '0;
    logic [2:0]  vd_sel = '0;
    logic [2:0]  vs_sel = '0;
    logic [15:0] offset = '0;
    logic [63:0] scalar = '0;
    logic [5:0]  vl_in = '0;
    logic        vstart_set = 1'b0;
    logic [5:0]  vstart_din = '0;
    logic        ld_en = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy, done, illegal, dirty;
    logic [5:0]  vstart_q;

    slide_unit u_slide_unit (
        .clk(clk), .rst(rst), .start(start), .op_in(op_in), .mask_en(mask_en),
        .ew_sel(ew_sel), .grp_sel(grp_sel), .vd_sel(vd_sel), .vs_sel(vs_sel),
        .offset(offset), .scalar(scalar), .vl_in(vl_in),
        .vstart_set(vstart_set), .vstart_din(vstart_din),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .illegal(illegal), .dirty(dirty), .vstart_q(vstart_q)
    );

    always #10 clk = ~clk;

    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;
    logic [7:0] ref_mem [BYTES];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_rd(input int base, input int idx, input int nb);
        logic [63:0] v = '0;
        for (int k = 0; k < nb; k++) v[8*k +: 8] = ref_mem[(base*VLENB + idx*nb + k) % BYTES];
        return v;
    endfunction

    task automatic ref_wr(input int base, input int idx, input int nb, input logic [63:0] v);
        for (int k = 0; k < nb; k++) ref_mem[(base*VLENB + idx*nb + k) % BYTES] = v[8*k +: 8];
    endtask

    // expected effect of one legal launch, built from R2..R8
    task automatic model(input vec_t v);
        int nb    = 1 << v.sew;
        int vlmax = (VLENB << v.lmul) / nb;
        int first = int'(v.vst);
        logic [31:0] m;
        for (int j = 0; j < 32; j++) m[j] = ref_mem[j/8][j%8];
        if (v.op == 2'd0 && int'(v.off) > first) first = int'(v.off);
        for (int i = first; i < int'(v.vl); i++) begin
            logic [63:0] val;
            if (v.msk && !m[i]) continue;
            case (v.op)
                2'd0: val = ref_rd(v.vs, i - int'(v.off), nb);
                2'd1: val = (i + int'(v.off) < vlmax) ? ref_rd(v.vs, i + int'(v.off), nb) : 64'h0;
                2'd2: val = (i == 0) ? v.sc : ref_rd(v.vs, i - 1, nb);
                default: val = (i + 1 < int'(v.vl)) ? ref_rd(v.vs, i + 1, nb) : v.sc;
            endcase
            ref_wr(v.vd, i, nb, val);
        end
    endtask

    task automatic poke(input int a, input logic [7:0] d);
        ld_en = 1'b1; ld_addr = 6'(a); ld_data = d;
        ref_mem[a] = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic fill(input int seed);
        for (int a = 0; a < BYTES; a++) poke(a, 8'((a*37 + seed*59 + 11) & 255));
    endtask

    task automatic drive_start(input vec_t v);
        op_in = v.op; ew_sel = v.sew; grp_sel = v.lmul; vd_sel = v.vd; vs_sel = v.vs;
        offset = v.off; vl_in = v.vl; mask_en = v.msk; scalar = v.sc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic set_vstart(input logic [5:0] s);
        vstart_set = 1'b1; vstart_din = s;
        @(negedge clk);
        vstart_set = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 600) begin
            @(negedge clk);
            n++;
        end
        check(done, req, "done seen", longint'(done), 1);
    endtask

    task automatic compare(input string req, input string what);
        int  first_bad = -1;
        logic [7:0] got = '0;
        for (int a = 0; a < BYTES; a++) begin
            rd_addr = 6'(a);
            #1;
            if (rd_data !== ref_mem[a] && first_bad < 0) begin
                first_bad = a;
                got = rd_data;
            end
        end
        if (first_bad < 0) check(1'b1, req, what, 0, 0);
        else check(1'b0, req, $sformatf("%s byte %0d", what, first_bad),
                   longint'(got), longint'(ref_mem[first_bad]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        vec_t d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(!busy && !done && !illegal && !dirty, "R1", "flags after reset",
              longint'({busy, done, illegal, dirty}), 0);
        check(vstart_q == 0, "R1", "vstart after reset", longint'(vstart_q), 0);
        for (int a = 0; a < BYTES; a++) ref_mem[a] = 8'h00;
        compare("R1", "storage after reset");

        // table of launches
        for (int t = 0; t < NV; t++) begin
            fill(t);
            set_vstart(TBL[t].vst);
            model(TBL[t]);
            drive_start(TBL[t]);
            wait_done($sformatf("R9 vec%0d", t));
            @(negedge clk);
            check(!done, "R9", $sformatf("done one cycle vec%0d", t), longint'(done), 0);
            check(vstart_q == 0, "R8", $sformatf("vstart cleared vec%0d", t), longint'(vstart_q), 0);
            check(dirty, "R9", $sformatf("dirty set vec%0d", t), longint'(dirty), 1);
            compare("R2-R7", $sformatf("storage vec%0d op%0d", t, TBL[t].op));
        end

        // R10 overlapping upward request is rejected
        fill(20);
        set_vstart(6'd3);
        d = '{2'd0, 2'd0, 2'd1, 3'd2, 3'd3, 16'd1, 6'd8, 6'd3, 1'b0, 64'h0};
        drive_start(d);
        check(illegal && !busy, "R10", "illegal pulse", longint'({illegal, busy}), 2);
        repeat (5) @(negedge clk);
        check(!done && !busy, "R10", "no run after reject", longint'({done, busy}), 0);
        check(vstart_q == 3, "R10", "vstart kept", longint'(vstart_q), 3);
        compare("R10", "storage untouched");

        // R10 downward in place with overlap is legal
        d = '{2'd1, 2'd0, 2'd0, 3'd2, 3'd2, 16'd1, 6'd8, 6'd3, 1'b0, 64'h0};
        model(d);
        drive_start(d);
        check(!illegal, "R10", "downward overlap accepted", longint'(illegal), 0);
        wait_done("R10");
        compare("R10", "in-place slide-down");

        // R12 reserved group size
        fill(21);
        d = '{2'd1, 2'd0, 2'd3, 3'd4, 3'd0, 16'd1, 6'd8, 6'd0, 1'b0, 64'h0};
        drive_start(d);
        check(illegal, "R12", "group size 3 rejected", longint'(illegal), 1);
        repeat (3) @(negedge clk);
        compare("R12", "storage untouched");

        // R6 mask captured at launch while the destination is register 0
        fill(22);
        poke(0, 8'b1010_1101);
        d = '{2'd1, 2'd0, 2'd0, 3'd0, 3'd1, 16'd0, 6'd8, 6'd0, 1'b1, 64'h0};
        set_vstart(6'd0);
        model(d);
        drive_start(d);
        wait_done("R6");
        compare("R6", "mask snapshot");

        // R11 start, vstart_set and loads ignored while busy
        fill(23);
        d = '{2'd3, 2'd0, 2'd2, 3'd4, 3'd0, 16'd0, 6'd32, 6'd0, 1'b0, 64'h33};
        model(d);
        drive_start(d);
        check(busy, "R11", "busy after launch", longint'(busy), 1);
        op_in = 2'd0; vd_sel = 3'd0; vs_sel = 3'd4; offset = 16'd2; start = 1'b1;
        ld_en = 1'b1; ld_addr = 6'd40; ld_data = 8'h77;
        vstart_set = 1'b1; vstart_din = 6'd5;
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0; vstart_set = 1'b0;
        wait_done("R11");
        @(negedge clk);
        check(vstart_q == 0, "R11", "vstart_set ignored", longint'(vstart_q), 0);
        check(!busy && !done, "R11", "second start ignored", longint'({busy, done}), 0);
        compare("R11", "only first operation applied");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule